// File: doc/BRIEF.md
# Capture/Compare Timer Event Flags

This block is a free-running 16-bit counter with one input-capture channel, one output-compare channel and a wrap event. Each event sets its own sticky flag. Software reads the three flags from a read-only status register over a simple byte-wide register bus. A flag is cleared only by a two-step sequence. First, software reads the status register while the flag is already set. Then it accesses the low-byte register that belongs to that flag.

The capture input passes through a two-flop synchronizer. A control bit selects whether a rising or a falling edge latches the counter. On a compare match, a stored level bit is copied to the compare output. A second control bit can route that output onto a shared pad in place of the pad's ordinary I/O. The flags power up at zero and are not touched by the synchronous functional reset.

Register offsets on `bus_addr`:

| Offset | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | read only |
| 2 | capture high byte | read only |
| 3 | capture low byte | read only |
| 4 | compare high byte | read/write |
| 5 | compare low byte | read/write |
| 6 | counter high byte | read only |
| 7 | counter low byte | read only |

Control register bits:

| Bit | Meaning |
|---|---|
| 0 | capture edge: 1 = rising, 0 = falling |
| 1 | compare output level |
| 2 | pad enable |

Top module: `ccp_timer`

## Requirements
- R1: A status read returns the capture flag in bit 7, the compare flag in bit 6 and the wrap flag in bit 5. Bits 4 to 0 always read 0.
- R2: A write to the status offset (1) changes no flag.
- R3: All three flags are 0 at power-up, and `rst` leaves them unchanged. `rst` performs the following:
  - it clears the control register, the counter, the capture register and all pending clear-arming;
  - it sets the compare register to FFFF.
- R4: Suppose the capture pin changes to the level selected by control bit 0 during a cycle in which the counter holds N. Two clock edges later, the capture register loads N+2 and the capture flag sets. A change to the other level captures nothing.
- R5: When the counter equals the compare register in a cycle, the compare flag sets at the next edge. At that same edge, `cmp_out` takes the value of control bit 1.
- R6: The wrap flag sets on the edge where the counter goes from FFFF to 0000. A status read issued in the FFFF cycle still returns the old flag value.
- R7: The first step of the clear sequence is a status read that sees the flag at 1. After it, the flag clears on the matching access, which is one of:
  - capture flag: a read of offset 3;
  - compare flag: a read or write of offset 5;
  - wrap flag: a read or write of offset 7.

  A flag does not clear in these cases: the matching access comes without that first step; the status read saw the flag at 0; the access is a write to offset 3.
- R8: If a flag's event occurs in the same cycle as the access that completes its clear, the flag stays set.
- R9: When control bit 2 is 0, `pad_out` and `pad_oe` follow `gpio_out` and `gpio_oe`. When control bit 2 is 1, `pad_out` follows `cmp_out` and `pad_oe` is 1.
- R10: The counter increments on every clock edge out of reset. A read of offset 6 returns the high byte, and a read of offset 7 the low byte, of the count held in the cycle of the read.
- R11: Read data appears on `bus_rdata` one clock edge after the read is presented. The control register reads back the full byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high functional reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_pin | input | 1 | Asynchronous capture input |
| gpio_out | input | 1 | Ordinary I/O drive value for the shared pad |
| gpio_oe | input | 1 | Ordinary I/O output enable for the shared pad |
| pad_out | output | 1 | Shared pad drive value |
| pad_oe | output | 1 | Shared pad output enable |
| cmp_out | output | 1 | Compare output level |

## Verification
The bench probes the clear sequence in several ways:
- A clearing access with no status read before it. A design that clears on the access alone would drop the flag early.
- A status read taken while the flag was still 0. A design that arms without looking at the flag would clear it on the later access.
- A write to the capture low byte, which must not clear the capture flag.

The bench also issues the compare low-byte read in exactly the cycle of a new match. A design that lets the clear win would lose that event.

The bench checks the following cycle-exact behaviour:
- A status read in the FFFF cycle must still show the wrap flag at 0.
- The captured value must be N+2. A design with a missing or extra synchronizer stage would be off by one.
- A reset pulse between the two steps must keep the flag and cancel the arming.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  // Register offsets on the byte bus
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_CAPH = 3'd2,
    REG_CAPL = 3'd3,
    REG_CMPH = 3'd4,
    REG_CMPL = 3'd5,
    REG_CNTH = 3'd6,
    REG_CNTL = 3'd7
  } reg_sel_e;

  // Flag indices inside the flag vector
  localparam int unsigned FLG_CAP = 0;
  localparam int unsigned FLG_CMP = 1;
  localparam int unsigned FLG_OVF = 2;
  localparam int unsigned NUM_FLG = 3;

  // Control register bit positions
  localparam int unsigned CTL_RISE  = 0;
  localparam int unsigned CTL_LEVEL = 1;
  localparam int unsigned CTL_PADEN = 2;

endpackage

// File: rtl/ccp_counter.sv
module ccp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // Next edge rolls the count over to zero
  assign wrap_o = !rst && (cnt_q == {CNT_W{1'b1}});
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/ccp_capture.sv
module ccp_capture #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             hit_o
);

  // Synchronizer plus one history stage; not reset so that the pipe
  // always reflects the real pin history across a functional reset.
  logic [SYNC_LEN:0] shr_q = '0;
  logic [CNT_W-1:0]  cap_q;
  logic              cur_lvl, old_lvl;

  always_ff @(posedge clk) begin
    shr_q <= {shr_q[SYNC_LEN-1:0], pin_i};
  end

  assign cur_lvl = shr_q[SYNC_LEN-1];
  assign old_lvl = shr_q[SYNC_LEN];
  assign hit_o   = !rst && (rise_i ? (cur_lvl && !old_lvl)
                                   : (!cur_lvl && old_lvl));

  always_ff @(posedge clk) begin
    if (rst)        cap_q <= '0;
    else if (hit_o) cap_q <= cnt_i;
  end

  assign cap_o = cap_q;

endmodule

// File: rtl/ccp_flag.sv
module ccp_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_acc_i,
  output logic flag_o,
  output logic arm_o
);

  // Power-on value only; the functional reset does not touch it
  logic flag_q = 1'b0;
  logic arm_q;

  always_ff @(posedge clk) begin
    if (set_i)                   flag_q <= 1'b1;
    else if (arm_q && clr_acc_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                      arm_q <= 1'b0;
    else if (clr_acc_i)           arm_q <= 1'b0;
    else if (stat_rd_i && flag_q) arm_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

endmodule

// File: rtl/ccp_timer.sv
module ccp_timer
  import ccp_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_pin,
  input  logic              gpio_out,
  input  logic              gpio_oe,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              cmp_out
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]   cmp_q;
  logic               lvl_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cap_val;
  logic               wrap_ev, cap_hit, cmp_hit;
  logic               rd_stb, wr_stb;
  logic               stat_rd, stat_wr;
  logic [NUM_FLG-1:0] set_vec, clr_vec, flag_vec, arm_vec;
  logic [DATA_W-1:0]  stat_byte, rd_mux;
  reg_sel_e           sel;

  assign sel    = reg_sel_e'(bus_addr);
  assign rd_stb = bus_sel && !bus_we;
  assign wr_stb = bus_sel && bus_we;
  assign stat_rd = rd_stb && (sel == REG_STAT);
  assign stat_wr = wr_stb && (sel == REG_STAT);

  ccp_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .wrap_o (wrap_ev)
  );

  ccp_capture #(.CNT_W(CNT_W), .SYNC_LEN(SYNC_LEN)) cap_i (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (cap_pin),
    .rise_i (ctrl_q[CTL_RISE]),
    .cnt_i  (cnt),
    .cap_o  (cap_val),
    .hit_o  (cap_hit)
  );

  // Control and compare registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= {CNT_W{1'b1}};
    end else if (wr_stb) begin
      case (sel)
        REG_CTRL: ctrl_q <= bus_wdata;
        REG_CMPH: cmp_q[CNT_W-1:DATA_W] <= bus_wdata;
        REG_CMPL: cmp_q[DATA_W-1:0]     <= bus_wdata;
        default:  ;
      endcase
    end
  end

  // Compare match and output-level transfer
  assign cmp_hit = !rst && (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)          lvl_q <= 1'b0;
    else if (cmp_hit) lvl_q <= ctrl_q[CTL_LEVEL];
  end

  // Event and clear-access vectors
  always_comb begin
    set_vec          = '0;
    set_vec[FLG_CAP] = cap_hit;
    set_vec[FLG_CMP] = cmp_hit;
    set_vec[FLG_OVF] = wrap_ev;
    clr_vec          = '0;
    clr_vec[FLG_CAP] = rd_stb  && (sel == REG_CAPL);
    clr_vec[FLG_CMP] = bus_sel && (sel == REG_CMPL);
    clr_vec[FLG_OVF] = bus_sel && (sel == REG_CNTL);
  end

  for (genvar g = 0; g < NUM_FLG; g++) begin : g_flag
    ccp_flag flg_i (
      .clk       (clk),
      .rst       (rst),
      .set_i     (set_vec[g]),
      .stat_rd_i (stat_rd),
      .clr_acc_i (clr_vec[g]),
      .flag_o    (flag_vec[g]),
      .arm_o     (arm_vec[g])
    );
  end

  // Read path
  always_comb begin
    stat_byte           = '0;
    stat_byte[DATA_W-1] = flag_vec[FLG_CAP];
    stat_byte[DATA_W-2] = flag_vec[FLG_CMP];
    stat_byte[DATA_W-3] = flag_vec[FLG_OVF];
    case (sel)
      REG_CTRL: rd_mux = ctrl_q;
      REG_STAT: rd_mux = stat_byte;
      REG_CAPH: rd_mux = cap_val[CNT_W-1:DATA_W];
      REG_CAPL: rd_mux = cap_val[DATA_W-1:0];
      REG_CMPH: rd_mux = cmp_q[CNT_W-1:DATA_W];
      REG_CMPL: rd_mux = cmp_q[DATA_W-1:0];
      REG_CNTH: rd_mux = cnt[CNT_W-1:DATA_W];
      REG_CNTL: rd_mux = cnt[DATA_W-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign cmp_out   = lvl_q;
  assign pad_out   = ctrl_q[CTL_PADEN] ? lvl_q : gpio_out;
  assign pad_oe    = ctrl_q[CTL_PADEN] ? 1'b1  : gpio_oe;

endmodule

// File: rtl/ccp_timer_chk.sv
module ccp_timer_chk
  import ccp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               stat_rd,
  input logic               stat_wr,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_FLG-1:0] set_vec,
  input logic [NUM_FLG-1:0] flag_vec,
  input logic [NUM_FLG-1:0] arm_vec,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   cmp_val,
  input logic               lvl_bit,
  input logic               cmp_out,
  input logic               cap_hit,
  input logic [CNT_W-1:0]   cap_val
);

  assert_stat_pad_R1: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rdata[DATA_W-4:0] == '0));

  assert_stat_wr_R2: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (flag_vec == ($past(flag_vec) | $past(set_vec))));

  assert_cap_val_R4: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> (cap_val == $past(cnt)));

  assert_cmp_lvl_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == cmp_val) |=> (cmp_out == $past(lvl_bit)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == {CNT_W{1'b1}}) |=> flag_vec[FLG_OVF]);

  assert_clear_armed_R7: assert property (@(posedge clk) disable iff (rst)
    ((~flag_vec & $past(flag_vec) & ~$past(arm_vec)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((flag_vec & $past(set_vec)) == $past(set_vec)));

endmodule

bind ccp_timer ccp_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .stat_rd  (stat_rd),
  .stat_wr  (stat_wr),
  .rdata    (bus_rdata),
  .set_vec  (set_vec),
  .flag_vec (flag_vec),
  .arm_vec  (arm_vec),
  .cnt      (cnt),
  .cmp_val  (cmp_q),
  .lvl_bit  (ctrl_q[ccp_pkg::CTL_LEVEL]),
  .cmp_out  (cmp_out),
  .cap_hit  (cap_hit),
  .cap_val  (cap_val)
);

// File: tb/ccp_timer_tb.sv
module ccp_timer_tb_top;
  import ccp_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0, gpio_out = 1'b1, gpio_oe = 1'b0;
  logic       pad_out, pad_oe, cmp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] m;

  ccp_timer dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .cmp_out(cmp_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Count model from R10: zero in reset, +1 per edge otherwise
  always @(posedge clk) begin
    if (rst) m <= '0;
    else     m <= m + 16'd1;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input reg_sel_e a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // Returns read data and the model count in the cycle of the read
  task automatic rdc(input reg_sel_e a, output logic [7:0] d, output logic [15:0] c);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; c = m;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd(input reg_sel_e a, output logic [7:0] d);
    logic [15:0] c;
    rdc(a, d, c);
  endtask

  task automatic set_cmp(input logic [15:0] v);
    wr(REG_CMPH, v[15:8]);
    wr(REG_CMPL, v[7:0]);
  endtask

  task automatic chk_cap(input string tag, input logic [15:0] exp);
    logic [7:0] h, l;
    rd(REG_CAPH, h);
    rd(REG_CAPL, l);
    chk(tag, {h, l}, exp);
  endtask

  initial begin
    logic [7:0]  d;
    logic [15:0] c, t;
    logic        lvl, pol;
    int          off;
    void'($urandom(32'h00C0FFEE));

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // Reset state
    rd(REG_STAT, d);  chk("R3 flags zero at power-up", d, 8'h00);
    rd(REG_CTRL, d);  chk("R3 control cleared", d, 8'h00);
    rd(REG_CMPH, d);  chk("R3 compare high FF", d, 8'hFF);
    rd(REG_CMPL, d);  chk("R3 compare low FF", d, 8'hFF);
    rd(REG_CAPH, d);  chk("R3 capture cleared", d, 8'h00);
    chk("R9 pad follows gpio value", pad_out, 1'b1);
    chk("R9 pad follows gpio enable", pad_oe, 1'b0);
    @(negedge clk); gpio_out = 1'b0; gpio_oe = 1'b1;
    #1;
    chk("R9 pad tracks gpio change", {pad_out, pad_oe}, 2'b01);

    // Counter readback
    rdc(REG_CNTH, d, c); chk("R10 counter high byte", d, c[15:8]);
    rdc(REG_CNTL, d, c); chk("R10 counter low byte", d, c[7:0]);

    // Control readback
    wr(REG_CTRL, 8'hA6);
    rd(REG_CTRL, d); chk("R11 control reads back", d, 8'hA6);

    // Compare with level 1 and pad enabled
    wr(REG_CTRL, 8'h06);
    set_cmp(m + 16'd40);
    repeat (50) @(negedge clk);
    chk("R5 compare output high", cmp_out, 1'b1);
    chk("R9 pad carries compare output", {pad_out, pad_oe}, 2'b11);
    rd(REG_CMPL, d);                        // access without prior status read
    rd(REG_STAT, d); chk("R7 no clear without status read", d, 8'h40);
    wr(REG_STAT, 8'h00);
    rd(REG_STAT, d); chk("R2 status write keeps flag", d, 8'h40);
    rd(REG_CMPL, d);
    rd(REG_STAT, d); chk("R7 compare flag cleared", d, 8'h00);
    wr(REG_STAT, 8'hFF);
    rd(REG_STAT, d); chk("R2 status write sets nothing", d, 8'h00);

    // Status read while flag is 0 must not arm
    wr(REG_CTRL, 8'h04);
    set_cmp(m + 16'd30);
    repeat (40) @(negedge clk);
    chk("R5 compare output low", cmp_out, 1'b0);
    chk("R9 pad low", pad_out, 1'b0);
    rd(REG_CMPL, d);
    rd(REG_STAT, d); chk("R7 stale read does not arm", d, 8'h40);
    rd(REG_CMPL, d);
    rd(REG_STAT, d); chk("R7 compare flag cleared again", d, 8'h00);

    // Set wins over clear in the same cycle
    set_cmp(m + 16'd30);
    repeat (40) @(negedge clk);
    t = m + 16'd100;
    set_cmp(t);
    rd(REG_STAT, d); chk("R8 flag set before arming", d, 8'h40);
    while (m != t) @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = REG_CMPL;
    @(negedge clk); bus_sel = 1'b0;
    rd(REG_STAT, d); chk("R8 set wins over clear", d, 8'h40);
    rd(REG_CMPL, d);
    rd(REG_STAT, d); chk("R7 flag cleared after race", d, 8'h00);

    // Capture, rising edge
    wr(REG_CTRL, 8'h01);
    cap_pin = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk); cap_pin = 1'b1; c = m;
    repeat (6) @(negedge clk);
    chk_cap("R4 rising capture value", c + 16'd2);
    rd(REG_STAT, d); chk("R1 R4 capture flag bit 7 only", d, 8'h80);
    wr(REG_CAPL, 8'h00);
    rd(REG_STAT, d); chk("R7 capture low write does not clear", d, 8'h80);
    rd(REG_CAPL, d);
    rd(REG_STAT, d); chk("R7 capture flag cleared", d, 8'h00);
    @(negedge clk); cap_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(REG_STAT, d); chk("R4 other edge ignored flag", d, 8'h00);
    chk_cap("R4 other edge keeps value", c + 16'd2);

    // Capture, falling edge
    wr(REG_CTRL, 8'h00);
    @(negedge clk); cap_pin = 1'b1;
    repeat (6) @(negedge clk);
    rd(REG_STAT, d); chk("R4 rising ignored in falling mode", d, 8'h00);
    @(negedge clk); cap_pin = 1'b0; c = m;
    repeat (6) @(negedge clk);
    chk_cap("R4 falling capture value", c + 16'd2);
    rd(REG_STAT, d); chk("R4 falling sets flag", d, 8'h80);
    rd(REG_CAPL, d);
    rd(REG_STAT, d); chk("R7 capture flag cleared falling", d, 8'h00);

    // Random mix of compare and capture
    for (int i = 0; i < 8; i++) begin
      lvl = 1'($urandom % 2);
      pol = 1'($urandom % 2);
      off = 20 + int'($urandom % 150);
      wr(REG_CTRL, {5'd0, 1'b1, lvl, pol});
      set_cmp(m + 16'(off));
      repeat (off + 10) @(negedge clk);
      chk("R5 random compare level", cmp_out, lvl);
      chk("R9 random pad level", pad_out, lvl);
      rd(REG_STAT, d); chk("R5 random compare flag", d & 8'h40, 8'h40);
      rd(REG_CMPL, d);
      rd(REG_STAT, d); chk("R7 random compare clear", d & 8'h40, 8'h00);
      @(negedge clk); cap_pin = ~pol;
      repeat (5) @(negedge clk);
      cap_pin = pol; c = m;
      repeat (3 + ($urandom % 5)) @(negedge clk);
      chk_cap("R4 random capture value", c + 16'd2);
      rd(REG_STAT, d); chk("R4 random capture flag", d & 8'h80, 8'h80);
      rd(REG_CAPL, d);
      rd(REG_STAT, d); chk("R7 random capture clear", d & 8'h80, 8'h00);
    end

    // Wrap flag, cycle exact
    while (m != 16'hFFFE) @(negedge clk);
    rd(REG_STAT, d); chk("R6 read in FFFF cycle sees old flag", d & 8'h20, 8'h00);
    rd(REG_STAT, d); chk("R6 wrap flag set", d & 8'h20, 8'h20);

    // Reset between the two clear steps
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    rd(REG_CTRL, d); chk("R3 reset clears control", d, 8'h00);
    chk("R3 R9 pad back to gpio", pad_out, gpio_out);
    rd(REG_CNTL, d);
    rd(REG_STAT, d); chk("R3 flag survives reset and arm dropped", d & 8'h20, 8'h20);
    rd(REG_CNTL, d);
    rd(REG_STAT, d); chk("R7 wrap flag cleared", d & 8'h20, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule